// File: doc/BRIEF.md
# Multichannel Trapezoidal Pulse Shaper

This block shapes the pulses that a detector preamplifier produces into trapezoids, so that a later stage can read the pulse energy from a flat top. It does this with a finite impulse response filter. The taps of that filter are the inverse of the pulse response, which collapses each pulse to a single spike, convolved with a trapezoid of chosen length and rise time. The taps arrive as one packed parameter vector. Typical settings are length 8 with rise time 1, length 16 with rise time 8, and length 16 with rise time 6, all counted in samples.

Four independent channels run side by side. Each channel accepts one signed 14-bit sample per clock and is meant to run at a 125 MHz sample rate. The multiply-accumulate uses no multipliers. Each input bit plane addresses its own copy of 16-entry partial-sum tables, which are built at elaboration from the tap vector, one table for every group of four taps. A shift-and-add stage weights the bit-plane sums and subtracts the sign plane. The accumulator is then scaled by a right shift with round-half-up and saturated to the output width.

Top module: `trap_shaper`

## Requirements
- R1: While `rst_n` is low at a rising edge, every `out_valid` bit is 0 and every `out_data` lane is 0 after that edge. Every delay line is cleared, so the first outputs after reset treat all earlier samples as zero.
- R2: A sample taken at a rising edge with its `in_valid` bit high produces `out_valid` high on that channel after the third following rising edge, and only then. The output therefore appears four edges after capture, counting the capture edge.
- R3: For each valid sample n, the raw result is y = sum over k of c[k]·x[n−k]. Here c[k] is the signed CW-bit field at bits [k·CW +: CW] of `COEFS`, and x[n−k] is the k-th earlier valid sample of that channel.
- R4: A cycle with `in_valid` low on a channel does not advance that channel's delay line and produces no output for it. The next valid sample continues the same sample sequence.
- R5: The channels are independent: the samples and valid pattern of one lane never change the outputs of another lane.
- R6: The value on `out_data` is floor((y + 2^(SHR−1)) / 2^SHR), which is rounding half-up, so −1632 with SHR = 6 gives −25 and +1632 gives +26.
- R7: Results above 2^(OW−1)−1 are output as 2^(OW−1)−1, and results below −2^(OW−1) are output as −2^(OW−1).
- R8: Input samples are two's complement. Full-scale negative −2^(DW−1) is treated as negative, through a subtracted sign bit plane.
- R9: On a channel whose `out_valid` is low, `out_data` holds the last value that was output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NCH | Per-channel sample strobe |
| in_data | input | NCH×DW | Per-channel signed sample, lane c at [c] |
| out_valid | output | NCH | Per-channel shaped-result strobe |
| out_data | output | NCH×OW | Per-channel rounded, saturated shaped result |

## Verification
The hardest case to reach from the ports is saturation. It needs full-scale samples of opposite sign lined up exactly under the positive and negative taps. No realistic pulse train does that. The bench therefore drives one full-scale negative sample followed by seven full-scale positive samples, and then the mirror image, which pushes the accumulator past both output limits. Exact half-way rounding is reached with ±16 impulses, whose products with a tap of 102 fall on a half step. Gapped valid patterns and Poisson-spaced exponential pulses on all lanes exercise delay-line hold and channel independence against a direct convolution.

// File: rtl/trap_pkg.sv
// Package trap_pkg
// Shared constants for the distributed-arithmetic shaper: the number of taps
// folded into one partial-sum table, and the resulting table depth.
package trap_pkg;
    localparam int unsigned TAP_GROUP = 4;
    localparam int unsigned LUT_DEPTH = 1 << TAP_GROUP;
endpackage

// File: rtl/trap_delay_line.sv
// Module trap_delay_line
// Per-channel tap register chain. taps[0] holds the newest valid sample,
// taps[k] the sample k valid cycles older. Assumes shift_en is the channel's
// sample strobe; nothing moves when it is low.
module trap_delay_line #(
    parameter int DW    = 14,
    parameter int NTAPS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic [DW-1:0]               din,
    output logic [NTAPS-1:0][DW-1:0]    taps
);
    // Shift a new sample in on each valid cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
            for (int k = 1; k < NTAPS; k++) begin
                taps[k] <= taps[k-1];
            end
        end
    end
endmodule

// File: rtl/trap_da_plane.sv
// Module trap_da_plane
// One input bit plane of the distributed-arithmetic product. The taps are split
// into groups of TAP_GROUP, and each group's bits address a constant table of
// coefficient partial sums computed at elaboration. The group results are
// added and registered. Assumes COEFS packs tap k at [k*CW +: CW].
module trap_da_plane
    import trap_pkg::*;
#(
    parameter int                    NTAPS = 8,
    parameter int                    CW    = 16,
    parameter int                    LW    = CW + 2,
    parameter int                    PW    = LW + 2,
    parameter logic [NTAPS*CW-1:0]   COEFS = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTAPS-1:0]         bits,
    output logic signed [PW-1:0]     psum
);
    localparam int NG = (NTAPS + TAP_GROUP - 1) / TAP_GROUP;

    // Sum of the coefficients of group g whose address bit is set.
    function automatic logic signed [LW-1:0] lut_entry(input int g, input int a);
        logic signed [LW-1:0] s;
        s = '0;
        for (int i = 0; i < TAP_GROUP; i++) begin
            if ((g * TAP_GROUP + i) < NTAPS && a[i]) begin
                s = s + LW'($signed(COEFS[(g*TAP_GROUP+i)*CW +: CW]));
            end
        end
        return s;
    endfunction

    logic signed [LW-1:0]        lut [NG][LUT_DEPTH];
    logic [NG*TAP_GROUP-1:0]     bits_pad;
    logic signed [PW-1:0]        psum_c;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar a = 0; a < LUT_DEPTH; a++) begin : g_ent
            localparam logic signed [LW-1:0] ENT = lut_entry(g, a);
            assign lut[g][a] = ENT;
        end
    end

    assign bits_pad = (NG*TAP_GROUP)'(bits);

    // Look up every group's table and add the partial sums.
    always_comb begin
        psum_c = '0;
        for (int g = 0; g < NG; g++) begin
            psum_c = psum_c + PW'(lut[g][bits_pad[g*TAP_GROUP +: TAP_GROUP]]);
        end
    end

    // Register the plane result.
    always_ff @(posedge clk) begin
        if (!rst_n) psum <= '0;
        else        psum <= psum_c;
    end
endmodule

// File: rtl/trap_out_scale.sv
// Module trap_out_scale
// Weights each bit-plane sum by its bit position and subtracts the sign plane
// (two's-complement input). The total is registered in an accumulator too wide
// to overflow. It is then rounded half-up by a right shift of SHR, saturated to
// OW bits and registered as the channel output. The output value holds when no
// result arrives.
module trap_out_scale #(
    parameter int DW   = 14,
    parameter int PW   = 20,
    parameter int ACCW = PW + DW + 1,
    parameter int OW   = 18,
    parameter int SHR  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [DW-1:0][PW-1:0]     psums,
    output logic signed [ACCW-1:0]    acc_q,
    output logic                      out_vld,
    output logic [OW-1:0]             out_q
);
    localparam logic signed [ACCW:0] HALF = (ACCW+1)'((64'd1 << SHR) >> 1);
    localparam logic signed [ACCW:0] SMAX = (ACCW+1)'((64'd1 << (OW-1)) - 64'd1);
    localparam logic signed [ACCW:0] SMIN = -SMAX - (ACCW+1)'(1);

    logic signed [ACCW-1:0] acc_c;
    logic                   acc_vld;
    logic signed [ACCW:0]   wide;
    logic signed [ACCW:0]   scaled;
    logic [OW-1:0]          sat_c;

    // Shift-and-add of the bit planes, sign plane subtracted.
    always_comb begin
        acc_c = '0;
        for (int j = 0; j < DW; j++) begin
            if (j == DW - 1) acc_c = acc_c - (ACCW'($signed(psums[j])) <<< j);
            else             acc_c = acc_c + (ACCW'($signed(psums[j])) <<< j);
        end
    end

    // Register the accumulator and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            acc_vld <= 1'b0;
        end else begin
            acc_q   <= acc_c;
            acc_vld <= in_vld;
        end
    end

    // Round half-up, shift, then clamp into the output range.
    always_comb begin
        wide   = $signed({acc_q[ACCW-1], acc_q}) + HALF;
        scaled = wide >>> SHR;
        if (scaled > SMAX)      sat_c = SMAX[OW-1:0];
        else if (scaled < SMIN) sat_c = SMIN[OW-1:0];
        else                    sat_c = scaled[OW-1:0];
    end

    // Output register: loads only with a result, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= acc_vld;
            if (acc_vld) out_q <= sat_c;
        end
    end
endmodule

// File: rtl/trap_channel.sv
// Module trap_channel
// One complete shaping lane: delay line, one distributed-arithmetic plane per
// input bit, then the weighting, rounding and saturation stage. The strobe
// pipeline runs alongside the data so that out_vld marks the result of each
// valid sample.
module trap_channel
    import trap_pkg::*;
#(
    parameter int                    DW    = 14,
    parameter int                    CW    = 16,
    parameter int                    NTAPS = 8,
    parameter int                    OW    = 18,
    parameter int                    SHR   = 6,
    parameter logic [NTAPS*CW-1:0]   COEFS = '0,
    parameter int                    ACCW  = 35
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [DW-1:0]            din,
    output logic                     out_vld,
    output logic [OW-1:0]            dout,
    output logic [DW-1:0]            head,
    output logic [ACCW-1:0]          acc
);
    localparam int NG = (NTAPS + TAP_GROUP - 1) / TAP_GROUP;
    localparam int LW = CW + $clog2(TAP_GROUP);
    localparam int PW = LW + $clog2(NG) + 1;

    logic [NTAPS-1:0][DW-1:0]  taps;
    logic [DW-1:0][NTAPS-1:0]  plane_bits;
    logic [DW-1:0][PW-1:0]     psums;
    logic                      vld_dl;
    logic                      vld_pl;
    logic signed [ACCW-1:0]    acc_s;

    trap_delay_line #(.DW(DW), .NTAPS(NTAPS)) u_dl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_vld),
        .din      (din),
        .taps     (taps)
    );

    // Transpose taps into bit planes.
    always_comb begin
        for (int j = 0; j < DW; j++) begin
            for (int k = 0; k < NTAPS; k++) begin
                plane_bits[j][k] = taps[k][j];
            end
        end
    end

    for (genvar j = 0; j < DW; j++) begin : g_plane
        logic signed [PW-1:0] ps;
        trap_da_plane #(
            .NTAPS(NTAPS), .CW(CW), .LW(LW), .PW(PW), .COEFS(COEFS)
        ) u_plane (
            .clk   (clk),
            .rst_n (rst_n),
            .bits  (plane_bits[j]),
            .psum  (ps)
        );
        assign psums[j] = ps;
    end

    // Strobe pipeline matching the delay-line and plane registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_dl <= 1'b0;
            vld_pl <= 1'b0;
        end else begin
            vld_dl <= in_vld;
            vld_pl <= vld_dl;
        end
    end

    trap_out_scale #(
        .DW(DW), .PW(PW), .ACCW(ACCW), .OW(OW), .SHR(SHR)
    ) u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (vld_pl),
        .psums   (psums),
        .acc_q   (acc_s),
        .out_vld (out_vld),
        .out_q   (dout)
    );

    assign head = taps[0];
    assign acc  = acc_s;
endmodule

// File: rtl/trap_shaper.sv
// Module trap_shaper
// Top level: NCH identical, independent trapezoidal shaping lanes sharing one
// fixed coefficient vector. Assumes one sample per clock per lane at most and
// a synchronous active-low reset held for at least one edge.
module trap_shaper
    import trap_pkg::*;
#(
    parameter int                    NCH   = 4,
    parameter int                    DW    = 14,
    parameter int                    CW    = 16,
    parameter int                    NTAPS = 8,
    parameter int                    OW    = 18,
    parameter int                    SHR   = 6,
    parameter logic [NTAPS*CW-1:0]   COEFS = {
        -16'sd922, 16'sd102, 16'sd102, 16'sd102,
         16'sd102, 16'sd102, 16'sd102, 16'sd1024}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           in_valid,
    input  logic [NCH-1:0][DW-1:0]   in_data,
    output logic [NCH-1:0]           out_valid,
    output logic [NCH-1:0][OW-1:0]   out_data
);
    localparam int NG   = (NTAPS + TAP_GROUP - 1) / TAP_GROUP;
    localparam int LW   = CW + $clog2(TAP_GROUP);
    localparam int PW   = LW + $clog2(NG) + 1;
    localparam int ACCW = PW + DW + 1;

    logic [NCH-1:0][DW-1:0]   dl_head;
    logic [NCH-1:0][ACCW-1:0] acc_all;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        trap_channel #(
            .DW(DW), .CW(CW), .NTAPS(NTAPS), .OW(OW), .SHR(SHR),
            .COEFS(COEFS), .ACCW(ACCW)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (in_valid[c]),
            .din     (in_data[c]),
            .out_vld (out_valid[c]),
            .dout    (out_data[c]),
            .head    (dl_head[c]),
            .acc     (acc_all[c])
        );
    end
endmodule

// File: rtl/trap_shaper_chk.sv
// Module trap_shaper_chk
// Property checker bound to trap_shaper. It watches the ports, the newest
// delay-line entry and the accumulator of each lane.
module trap_shaper_chk #(
    parameter int NCH  = 4,
    parameter int DW   = 14,
    parameter int OW   = 18,
    parameter int ACCW = 35
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH-1:0]           in_valid,
    input logic [NCH-1:0][DW-1:0]   in_data,
    input logic [NCH-1:0]           out_valid,
    input logic [NCH-1:0][OW-1:0]   out_data,
    input logic [NCH-1:0][DW-1:0]   dl_head,
    input logic [NCH-1:0][ACCW-1:0] acc_all
);
    logic [2:0] run_cnt;

    // Count edges since reset release, saturating at 4.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (run_cnt != 3'd4) run_cnt <= run_cnt + 3'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2
        latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_cnt == 3'd4) |-> (out_valid[c] == $past(in_valid[c], 4)));

        // R4
        dl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid[c] |=> $stable(dl_head[c]));

        // R4
        dl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid[c] |=> (dl_head[c] == $past(in_data[c])));

        // R9
        out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[c] |-> $stable(out_data[c]));

        // R6
        pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[c] && !$past(acc_all[c][ACCW-1])) |-> !out_data[c][OW-1]);

        // R6
        neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[c] && $past(acc_all[c][ACCW-1]))
                |-> (out_data[c][OW-1] || out_data[c] == '0));
    end
endmodule

bind trap_shaper trap_shaper_chk #(
    .NCH(NCH), .DW(DW), .OW(OW), .ACCW(ACCW)
) u_trap_shaper_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .dl_head   (dl_head),
    .acc_all   (acc_all)
);

// File: tb/trap_shaper_bench.sv
module trap_shaper_bench;
    localparam int CLK_PERIOD = 8;
    localparam int NCH = 4;
    localparam int DW  = 14;
    localparam int OW  = 18;
    localparam int NT  = 8;
    localparam int SHR = 6;
    localparam int QD  = 64;
    localparam longint OMAX = (64'sd1 <<< (OW-1)) - 1;
    localparam longint OMIN = -(64'sd1 <<< (OW-1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NCH-1:0]          in_valid = '0;
    logic [NCH-1:0][DW-1:0]  in_data = '0;
    logic [NCH-1:0]          out_valid;
    logic [NCH-1:0][OW-1:0]  out_data;

    int     coef [NT] = '{1024, 102, 102, 102, 102, 102, 102, -922};
    int     hist [NCH][NT];
    longint exp_val [NCH][QD];
    int     exp_cyc [NCH][QD];
    string  exp_tag [NCH][QD];
    int     wr [NCH];
    int     rd [NCH];
    longint last_out [NCH];
    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;

    logic   nv [NCH];
    int     nd [NCH];
    string  ntag = "R3";
    int     lvl [NCH];

    trap_shaper u_trap_shaper (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    // Compare outputs seen at this negedge with the queued expectations.
    task automatic monitor();
        for (int c = 0; c < NCH; c++) begin
            longint got = longint'($signed(out_data[c]));
            bit pend = (rd[c] != wr[c]);
            if (out_valid[c]) begin
                if (!pend || exp_cyc[c][rd[c] % QD] != cyc) begin
                    check(0, "R2/R4 unexpected out_valid", 1, 0);
                end else begin
                    check(got == exp_val[c][rd[c] % QD], exp_tag[c][rd[c] % QD],
                          got, exp_val[c][rd[c] % QD]);
                    last_out[c] = exp_val[c][rd[c] % QD];
                    rd[c]++;
                end
            end else begin
                if (pend && exp_cyc[c][rd[c] % QD] == cyc) begin
                    check(0, "R2 missing out_valid", 0, 1);
                    rd[c]++;
                end
                check(got == last_out[c], "R9 hold", got, last_out[c]);
            end
        end
    endtask

    // One clock: check, then drive nv/nd and queue expected results.
    task automatic step();
        @(negedge clk);
        cyc++;
        monitor();
        for (int c = 0; c < NCH; c++) begin
            in_valid[c] = nv[c];
            in_data[c]  = nd[c][DW-1:0];
            if (nv[c]) begin
                longint y = 0;
                longint r;
                for (int k = NT-1; k > 0; k--) hist[c][k] = hist[c][k-1];
                hist[c][0] = nd[c];
                for (int k = 0; k < NT; k++) y += longint'(coef[k]) * longint'(hist[c][k]);
                r = (y + (64'sd1 <<< (SHR-1))) >>> SHR;
                if (r > OMAX) r = OMAX;
                if (r < OMIN) r = OMIN;
                exp_val[c][wr[c] % QD] = r;
                exp_cyc[c][wr[c] % QD] = cyc + 4;
                exp_tag[c][wr[c] % QD] = ntag;
                wr[c]++;
            end
        end
    endtask

    task automatic idle_all();
        for (int c = 0; c < NCH; c++) begin nv[c] = 0; nd[c] = 0; end
    endtask

    task automatic one(input int ch, input int d);
        idle_all();
        nv[ch] = 1; nd[ch] = d;
        step();
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            wr[c] = 0; rd[c] = 0; last_out[c] = 0; lvl[c] = 0;
            for (int k = 0; k < NT; k++) hist[c][k] = 0;
        end
        idle_all();
        in_valid = '1;
        in_data  = '1;
        repeat (4) @(negedge clk);
        in_valid = '0;
        in_data  = '0;
        @(negedge clk);
        // R1: reset state of the outputs
        check(out_valid == '0, "R1 out_valid in reset", longint'(out_valid), 0);
        check(out_data == '0, "R1 out_data in reset", 0, 0);
        rst_n = 1'b1;

        // R1 R3: impulse after reset reads the taps back, history zero
        ntag = "R1/R3 impulse";
        one(0, 1000);
        for (int i = 0; i < 9; i++) one(0, 0);

        // R6: half-way rounding, both signs
        ntag = "R6 round half-up";
        one(1, 16);
        for (int i = 0; i < 8; i++) one(1, 0);
        one(1, -16);
        for (int i = 0; i < 8; i++) one(1, 0);

        // R8: full-scale negative sample
        ntag = "R8 full-scale negative";
        one(2, -8192);
        for (int i = 0; i < 8; i++) one(2, 0);

        // R7: positive then negative saturation
        ntag = "R7 saturate high";
        one(3, -8192);
        for (int i = 0; i < 7; i++) one(3, 8191);
        ntag = "R7 saturate low";
        one(3, 8191);
        for (int i = 0; i < 7; i++) one(3, -8192);
        for (int i = 0; i < 8; i++) one(3, 0);

        // R4: gapped valid patterns, ramp data
        ntag = "R4 gapped valid";
        for (int t = 0; t < 60; t++) begin
            for (int c = 0; c < NCH; c++) begin
                nv[c] = ((t + c) % (c + 2)) != 0;
                nd[c] = (t * 137 + c * 991) % 8000 - 4000;
            end
            step();
        end

        // R5: one busy lane beside quiet valid lanes
        ntag = "R5 independence";
        for (int t = 0; t < 40; t++) begin
            for (int c = 0; c < NCH; c++) begin
                nv[c] = 1;
                nd[c] = (c == 0) ? ((t % 2) ? 8191 : -8192) : 0;
            end
            step();
        end

        // R3 R5: Poisson-spaced exponential pulses on every lane
        ntag = "R3/R5 pulse train";
        for (int t = 0; t < 3000; t++) begin
            for (int c = 0; c < NCH; c++) begin
                int v;
                lvl[c] = lvl[c] - (lvl[c] >>> 3);
                if ($urandom_range(0, 24) == 0) lvl[c] += int'($urandom_range(500, 4000));
                v = lvl[c] + int'($urandom_range(0, 8)) - 4;
                if (v > 8191) v = 8191;
                if (v < -8192) v = -8192;
                nv[c] = ($urandom_range(0, 9) != 0);
                nd[c] = v;
            end
            step();
        end

        idle_all();
        ntag = "R9 drain";
        for (int i = 0; i < 12; i++) step();
        for (int c = 0; c < NCH; c++) begin
            check(rd[c] == wr[c], "R2 all results delivered", rd[c], wr[c]);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog cycle=%0d actual=timeout expected=done", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule